// File: doc/BRIEF.md
# Hierarchical Clear-On-Read Interrupt Controller

This block gathers interrupt events from four channels into a tree of status registers. A host reaches the tree over a simple register bus. Each channel holds five 8-bit leaf status registers, and each leaf has its own 8-bit enable mask. Event pulses on `evt_i` set leaf bits. A set mask bit lets the matching bit through, and a clear mask bit blocks it. Above the leaves, a channel summary marks which leaves of that channel hold pending enabled bits. A global summary marks which channels have a non-empty channel summary. One registered, active-high interrupt line is driven from the enabled pending bits.

The host services an interrupt by walking down the tree:
- It reads the global summary, then the summary of the flagged channel, then the flagged leaf.
- Reading a leaf clears the whole register.
- The two summary levels are derived from the leaves. They therefore follow the leaves at once: they point at whatever is still pending, or clear when nothing remains.

A configuration bit selects a visible mode. In that mode, masked bits are still recorded in the leaves so that software can poll them. They never reach the summaries or the interrupt line.

Address map:
- The upper nibble of `bus_addr` picks a region. Region 0 holds the global summary at 0x00 and the configuration register at 0x01.
- Region c+1 belongs to channel c. Inside it, offset r (0 to 4) is leaf r, offset 8+r is the mask of leaf r, and offset 0xF is the channel summary.
- Read data is registered. It appears one clock edge after the edge that samples `bus_rd`.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset all leaf registers, masks and the configuration bit read as 0x00, and `irq_o` is low.
- R2: An event bit on `evt_i[(c*5+r)*8+b]` whose mask bit is set is captured at the next clock edge. It reads back as bit b of leaf r of channel c, at address 0x10*(c+1)+r. Leaf bits are set by events only.
- R3: Channel summary bit r (address 0x10*(c+1)+0xF) is 1 when leaf r of channel c holds a bit that is both set and enabled. Global summary bit c (address 0x00) is 1 when the summary of channel c is non-zero.
- R4: A read of a leaf returns its contents and clears all of its bits at the same edge, masked or not. The summaries then point at any remaining pending leaf, or read zero.
- R5: `irq_o` is high exactly one clock edge after an enabled pending leaf bit exists. It falls one edge after the last such bit is cleared by reading.
- R6: An event that arrives in the same cycle as a read of its own leaf is not lost. That read returns the value before the event, and the bit reads as set on the next read.
- R7: With configuration bit 0 clear (default mode), an event on a masked bit is not recorded.
- R8: With configuration bit 0 set (visible mode), an event on a masked bit is recorded in its leaf. It appears neither in the channel summary, nor in the global summary, nor on `irq_o`.
- R9: Enabled bits are captured and summarized the same way in both modes.
- R10: Masks at offset 8+r and the configuration register at 0x01 (bit 0) are read/write. Both summary registers are read-only, so writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 160 | Event pulses, bit (c*5+r)*8+b for channel c, leaf r, bit b |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
The timing of each result is fixed:
- An event driven before edge k sets its leaf at edge k. Both summaries reflect it right away, so a read strobed at edge k+1 sees it. `irq_o` rises at edge k+1.
- Read data for a strobe sampled at edge k is compared on the falling edge after k. A scoreboard queue holds one expected byte per issued read, so each comparison lands on exactly that cycle.
- The interrupt line is checked only after at least one full idle or read cycle has passed since the edge that changed the leaves. This means a leaf clear at edge k is judged after edge k+1.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int REGION_W = 4;
  localparam int OFFS_W   = ADDR_W - REGION_W;
  localparam logic [OFFS_W-1:0] OFS_GSUM = 4'h0;
  localparam logic [OFFS_W-1:0] OFS_CFG  = 4'h1;
  localparam int OFS_MASK_BASE = 8;
  localparam logic [OFFS_W-1:0] OFS_CSUM = 4'hF;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NREG = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_gsum_o,
  output logic              sel_cfg_o,
  output logic [NCH-1:0]    ch_sel_o,
  output logic [NREG-1:0]   off_stat_o,
  output logic [NREG-1:0]   off_mask_o,
  output logic              off_csum_o
);
  logic [REGION_W-1:0] region;
  logic [OFFS_W-1:0]   offs;

  always_comb begin
    region     = addr_i[ADDR_W-1:OFFS_W];
    offs       = addr_i[OFFS_W-1:0];
    sel_gsum_o = (region == '0) && (offs == OFS_GSUM);
    sel_cfg_o  = (region == '0) && (offs == OFS_CFG);
    off_csum_o = (offs == OFS_CSUM);
    for (int c = 0; c < NCH; c++)
      ch_sel_o[c] = (region == REGION_W'(c + 1));
    for (int r = 0; r < NREG; r++) begin
      off_stat_o[r] = (offs == OFFS_W'(r));
      off_mask_o[r] = (offs == OFFS_W'(OFS_MASK_BASE + r));
    end
  end
endmodule

// File: rtl/irq_chan.sv
module irq_chan #(
  parameter int NREG = 5,
  parameter int W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] evt_i,
  input  logic              vis_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [NREG-1:0]   off_stat_i,
  input  logic [NREG-1:0]   off_mask_i,
  input  logic              off_csum_i,
  input  logic [W-1:0]      wdata_i,
  output logic [NREG*W-1:0] stat_o,
  output logic [NREG*W-1:0] mask_o,
  output logic [NREG-1:0]   csum_o,
  output logic [W-1:0]      rdata_o
);
  localparam int PADW = W - NREG;

  for (genvar r = 0; r < NREG; r++) begin : g_leaf
    logic [W-1:0] stat_q, stat_d, mask_q, mask_d, cap;
    logic         rd_hit, wr_hit, stat_en;

    always_comb begin
      rd_hit  = sel_i & rd_i & off_stat_i[r];
      wr_hit  = sel_i & wr_i & off_mask_i[r];
      cap     = evt_i[r*W +: W] & (mask_q | {W{vis_i}});
      stat_d  = (rd_hit ? {W{1'b0}} : stat_q) | cap;
      stat_en = rd_hit | (|cap);
      mask_d  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= '0;
      else if (stat_en) stat_q <= stat_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (wr_hit) mask_q <= mask_d;
    end

    assign stat_o[r*W +: W] = stat_q;
    assign mask_o[r*W +: W] = mask_q;
    assign csum_o[r]        = |(stat_q & mask_q);
  end

  always_comb begin
    rdata_o = off_csum_i ? {{PADW{1'b0}}, csum_o} : {W{1'b0}};
    for (int r = 0; r < NREG; r++) begin
      if (off_stat_i[r]) rdata_o |= stat_o[r*W +: W];
      if (off_mask_i[r]) rdata_o |= mask_o[r*W +: W];
    end
  end
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NREG = 5,
  parameter int W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*NREG*W-1:0] evt_i,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [W-1:0]          bus_wdata,
  output logic [W-1:0]          bus_rdata,
  output logic                  irq_o
);
  localparam int CHW  = NREG * W;
  localparam int NBIT = NCH * CHW;

  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic                  sel_gsum, sel_cfg, off_csum, cfg_wr;
  logic [NCH-1:0]        ch_sel, gsum;
  logic [NREG-1:0]       off_stat, off_mask;
  logic [NCH-1:0][NREG-1:0] csum;
  logic [NCH-1:0][W-1:0] ch_rd;
  logic [NBIT-1:0]       stat_all, mask_all;
  logic                  vis_q, vis_d, irq_d;
  logic [W-1:0]          rdata_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  irq_addr_dec #(.NCH(NCH), .NREG(NREG)) u_dec (
    .addr_i    (bus_addr),
    .sel_gsum_o(sel_gsum),
    .sel_cfg_o (sel_cfg),
    .ch_sel_o  (ch_sel),
    .off_stat_o(off_stat),
    .off_mask_o(off_mask),
    .off_csum_o(off_csum)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_chan #(.NREG(NREG), .W(W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .evt_i     (evt_i[c*CHW +: CHW]),
      .vis_i     (vis_q),
      .sel_i     (ch_sel[c]),
      .rd_i      (bus_rd),
      .wr_i      (bus_wr),
      .off_stat_i(off_stat),
      .off_mask_i(off_mask),
      .off_csum_i(off_csum),
      .wdata_i   (bus_wdata),
      .stat_o    (stat_all[c*CHW +: CHW]),
      .mask_o    (mask_all[c*CHW +: CHW]),
      .csum_o    (csum[c]),
      .rdata_o   (ch_rd[c])
    );
    assign gsum[c] = |csum[c];
  end

  always_comb begin
    cfg_wr = bus_wr & sel_cfg;
    vis_d  = bus_wdata[0];
    irq_d  = |gsum;
    rdata_d = '0;
    if (sel_gsum)     rdata_d = {{(W-NCH){1'b0}}, gsum};
    else if (sel_cfg) rdata_d = {{(W-1){1'b0}}, vis_q};
    else begin
      for (int c = 0; c < NCH; c++)
        if (ch_sel[c]) rdata_d = ch_rd[c];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vis_q     <= 1'b0;
      irq_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (cfg_wr) vis_q     <= vis_d;
      irq_o <= irq_d;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end
endmodule

module irq_tree_chk #(
  parameter int NCH  = 4,
  parameter int NREG = 5,
  parameter int W    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH*NREG*W-1:0] evt,
  input logic                  rd,
  input logic [7:0]            addr,
  input logic [NCH*NREG*W-1:0] stat,
  input logic [NCH*NREG*W-1:0] mask,
  input logic                  vis,
  input logic                  irq
);
  localparam int NB = NCH * NREG * W;
  logic [NB-1:0] rd_vec, cap_v;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NREG; r++)
        rd_vec[(c*NREG+r)*W +: W] =
          {W{rd && (addr[7:4] == 4'(c + 1)) && (addr[3:0] == 4'(r))}};
    cap_v = evt & (mask | {NB{vis}});
  end

  AST_ONLY_EVENTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(cap_v)) == '0)); // R2

  AST_READ_CLEARS_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(rd_vec) & ~$past(cap_v)) == '0)); // R4

  AST_IRQ_FOLLOWS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & mask)))); // R5

  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cap_v) & ~stat) == '0)); // R6

  AST_DEFAULT_DROPS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(mask) & {NB{~$past(vis)}}) == '0)); // R7

  AST_VISIBLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && ((stat & mask) == '0)) |=> !irq); // R8
endmodule

bind irq_tree_ctrl irq_tree_chk #(.NCH(NCH), .NREG(NREG), .W(W)) u_chk (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .evt  (evt_i),
  .rd   (bus_rd),
  .addr (bus_addr),
  .stat (stat_all),
  .mask (mask_all),
  .vis  (vis_q),
  .irq  (irq_o)
);

// File: tb/sim_irq_tree_ctrl.sv
`timescale 1ns/1ps
module sim_irq_tree_ctrl;
  localparam int NCH = 4, NREG = 5, W = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NCH*NREG*W-1:0] evt = '0;
  logic                  bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]            bus_addr = '0, bus_wdata = '0;
  logic [W-1:0]          bus_rdata;
  logic                  irq;

  int total = 0, bad = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_d = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_tree_ctrl #(.NCH(NCH), .NREG(NREG), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  // monitor: read data for a strobe sampled at an edge is due on the next falling edge
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%02h exp=none", bus_rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%02h exp=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [W-1:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int c, input int r, input logic [W-1:0] v);
    @(negedge clk);
    evt[(c*NREG+r)*W +: W] = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic read_with_evt(input logic [7:0] a, input logic [W-1:0] e,
                               input int c, input int r, input logic [W-1:0] v,
                               input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    evt[(c*NREG+r)*W +: W] = v;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0; evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq act=%0b exp=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    idle(2);
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL reads pending act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    chk_irq(1'b0, "R1 reset irq");
    do_read(8'h00, 8'h00, "R1 reset global summary");
    do_read(8'h01, 8'h00, "R1 reset config");
    do_read(8'h18, 8'h00, "R1 reset mask ch0 leaf0");
    do_read(8'h44, 8'h00, "R1 reset leaf ch3 r4");

    // R10 mask read/write
    do_write(8'h1A, 8'hFF);
    do_write(8'h4C, 8'h0F);
    do_read(8'h1A, 8'hFF, "R10 mask ch0 leaf2 readback");
    do_read(8'h4C, 8'h0F, "R10 mask ch3 leaf4 readback");

    // R2 R3 R4 R5 default mode, two channels
    pulse(0, 2, 8'h20);
    pulse(3, 4, 8'h02);
    idle(1);
    chk_irq(1'b1, "R5 irq raised");
    do_read(8'h00, 8'h09, "R3 global summary two channels");
    do_read(8'h1F, 8'h04, "R3 channel0 summary");
    do_read(8'h12, 8'h20, "R2 leaf ch0 r2 content");
    do_read(8'h00, 8'h08, "R4 global summary points at ch3");
    chk_irq(1'b1, "R5 irq held while ch3 pending");
    do_read(8'h4F, 8'h10, "R3 channel3 summary");
    do_read(8'h44, 8'h02, "R2 leaf ch3 r4 content");
    do_read(8'h00, 8'h00, "R4 global summary cleared");
    chk_irq(1'b0, "R5 irq released");
    do_read(8'h12, 8'h00, "R4 leaf cleared after read");

    // R7 masked event dropped in default mode
    pulse(1, 0, 8'h08);
    idle(1);
    chk_irq(1'b0, "R7 masked event no irq");
    do_read(8'h20, 8'h00, "R7 masked event not recorded");

    // R10 summaries are read-only
    do_write(8'h00, 8'hFF);
    do_write(8'h2F, 8'hFF);
    do_read(8'h00, 8'h00, "R10 global summary write ignored");
    do_read(8'h2F, 8'h00, "R10 channel summary write ignored");

    // R8 visible mode
    do_write(8'h01, 8'h01);
    do_read(8'h01, 8'h01, "R10 config readback");
    pulse(1, 0, 8'h08);
    idle(1);
    chk_irq(1'b0, "R8 masked visible bit no irq");
    do_read(8'h00, 8'h00, "R8 global summary ignores masked");
    do_read(8'h2F, 8'h00, "R8 channel summary ignores masked");
    do_read(8'h20, 8'h08, "R8 masked bit visible in leaf");
    do_read(8'h20, 8'h00, "R4 masked bit cleared by read");

    // R9 mixed masked/unmasked in visible mode
    do_write(8'h29, 8'h01);
    pulse(1, 1, 8'h03);
    idle(1);
    chk_irq(1'b1, "R9 unmasked bit raises irq in visible mode");
    do_read(8'h00, 8'h02, "R9 global summary visible mode");
    do_read(8'h2F, 8'h02, "R9 channel1 summary visible mode");
    do_read(8'h21, 8'h03, "R9 leaf holds both bits");
    idle(1);
    chk_irq(1'b0, "R4 polling consumed unmasked bit");
    pulse(0, 2, 8'h20);
    do_read(8'h00, 8'h01, "R9 same capture as default mode");
    do_read(8'h12, 8'h20, "R9 leaf ch0 r2 visible mode");

    // R6 event during read of the same leaf
    do_write(8'h01, 8'h00);
    pulse(0, 2, 8'h01);
    read_with_evt(8'h12, 8'h01, 0, 2, 8'h40, "R6 read returns pre-event value");
    chk_irq(1'b1, "R6 irq stays for held event");
    do_read(8'h12, 8'h40, "R6 held event visible on next read");
    idle(1);
    chk_irq(1'b0, "R5 irq low after final clear");

    finish_run();
  end
endmodule